// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Option

This block is a watchdog counter for a small controller. It counts ticks from one of three tick inputs (an on-chip RC oscillator tick, the instruction-clock tick, or an external 32768 Hz tick). A fourth source setting switches the function off. When the counter has taken 2^CNT_W ticks since its last restart, the block raises a one-cycle timeout pulse, wraps to zero and keeps counting. Firmware must restart the counter in time to avoid the pulse.

Two restart policies are chosen by a static mode input. In single-clear mode one clear strobe restarts the counter. In dual-clear mode two separate clear commands, A and B, must both be seen. They may come in either order, or together, and each is held in a pending flag until its partner arrives. The source and mode inputs act as build-time options. A change of the source selection still restarts the counter cleanly.

Top module: `wdt_dual_clear`

## Requirements
- R1: `src_sel` encodes the count source: 0 = RC tick, 1 = instruction tick, 2 = external 32768 Hz tick. The counter advances only on cycles where the selected tick input is high, and the other tick inputs have no effect.
- R2: With `src_sel` = 3 the watchdog is off: the counter is held at zero and `timeout` never rises, whatever the tick inputs do.
- R3: `timeout` is high for exactly one cycle, the cycle after the 2^CNT_W-th counted tick since the last restart. The counter wraps to zero on that tick and keeps counting, so the next pulse follows another 2^CNT_W ticks.
- R4: With `dual_mode` = 0, a high `clr_single` restarts the counter to zero. `clr_a` and `clr_b` are ignored.
- R5: With `dual_mode` = 1, the counter restarts on the cycle in which both `clr_a` and `clr_b` have been seen since the last restart. The order may be A then B, B then A, or both in one cycle. Both pending flags are emptied on that restart.
- R6: With `dual_mode` = 1, repeating the same clear command never stands in for the other one. A partial sequence (only A, or only B) lets the timer expire on schedule.
- R7: With `dual_mode` = 1, `clr_single` is ignored.
- R8: Any change of `src_sel` restarts the counter and discards pending clear flags. After reset the previous source counts as 3.
- R9: A restart takes priority over a tick in the same cycle, and that tick is not counted. `timeout` and the counter are zero after the synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 2 | Count source: 0 RC, 1 instruction, 2 external 32 kHz, 3 off |
| dual_mode | input | 1 | 0: single clear command, 1: two clear commands needed |
| tick_rc | input | 1 | One-cycle tick from the RC oscillator domain |
| tick_instr | input | 1 | One-cycle instruction-clock tick |
| tick_ext | input | 1 | One-cycle tick from the external 32768 Hz source |
| clr_single | input | 1 | Clear strobe used in single-clear mode |
| clr_a | input | 1 | First dual-mode clear strobe |
| clr_b | input | 1 | Second dual-mode clear strobe |
| timeout | output | 1 | One-cycle pulse on counter overflow |

## Verification
The bench measures the period on every source while the unselected tick inputs toggle at random. A wrong multiplexer would shorten the measured period. It holds the off setting with all ticks high, so any leak would give a timeout. In dual mode it runs both orders, a simultaneous pair, a repeated single command and a lone command. A design that treats A and A as a pair, or that forgets a pending flag, would restart early or expire late. A source change between A and B exposes a pending flag that survives the change, because B would then restart the count a second time. A long random run against a bench model then catches off-by-one periods, and any tick that gets counted on a restart cycle.

// File: rtl/wdt_pkg.sv
// Package: shared types and constants for the dual-clear watchdog.
// Assumes: src_sel is a 2-bit code, with the top code meaning "off".
package wdt_pkg;

    typedef enum logic [1:0] {
        SRC_RC    = 2'd0,
        SRC_INSTR = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_OFF   = 2'd3
    } wdt_src_e;

    localparam int NUM_TICK_SRC = 3;

endpackage

// File: rtl/wdt_tick_mux.sv
// Module: wdt_tick_mux
// Chooses the tick input named by the source code, reports whether counting
// is enabled, and flags a change of source against the previous cycle.
// Assumes: tick inputs are already synchronous one-cycle enables.
module wdt_tick_mux
    import wdt_pkg::*;
#(
    parameter int NSRC = NUM_TICK_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_vec,
    input  wdt_src_e        src_sel,
    output logic            tick,
    output logic            enabled,
    output logic            src_chg
);

    logic [NSRC-1:0] hit;
    wdt_src_e        src_q;

    // One gated term for each source; only the selected one can fire.
    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        assign hit[g] = tick_vec[g] && (src_sel == wdt_src_e'(g));
    end

    // Merge the gated terms into a single count enable.
    always_comb begin
        tick    = |hit;
        enabled = (src_sel != SRC_OFF);
        src_chg = (src_sel != src_q);
    end

    // Remember the previous source; reset treats it as "off".
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_OFF;
        else        src_q <= src_sel;
    end

endmodule

// File: rtl/wdt_clear_seq.sv
// Module: wdt_clear_seq
// Turns clear strobes into a restart request under the selected policy.
// In dual mode it keeps one pending flag for each command and releases a
// restart once both commands are present.
// Assumes: dual_mode is static in normal use; leaving dual mode empties flags.
module wdt_clear_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode,
    input  logic clr_single,
    input  logic clr_a,
    input  logic clr_b,
    input  logic flush,
    output logic restart,
    output logic pend_a,
    output logic pend_b
);

    logic hit_a;
    logic hit_b;

    // Decide whether this cycle completes a clear under the active policy.
    always_comb begin
        hit_a = dual_mode && clr_a;
        hit_b = dual_mode && clr_b;
        if (!dual_mode) restart = clr_single;
        else            restart = (hit_a || pend_a) && (hit_b || pend_b);
    end

    // Hold the pending flags, empty them on restart, flush or single mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a <= 1'b0;
            pend_b <= 1'b0;
        end else if (flush || restart || !dual_mode) begin
            pend_a <= 1'b0;
            pend_b <= 1'b0;
        end else begin
            if (hit_a) pend_a <= 1'b1;
            if (hit_b) pend_b <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Free-running tick counter with restart priority and a registered
// one-cycle overflow pulse; wraps to zero on overflow.
// Assumes: CNT_W >= 1, so two pulses are always at least two cycles apart.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enabled,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count selected ticks; restart wins; pulse on the wrapping tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (restart) begin
                count <= '0;
            end else if (tick && enabled) begin
                count   <= count + 1'b1;
                timeout <= (count == CNT_MAX);
            end
        end
    end

endmodule

// File: rtl/wdt_dual_clear.sv
// Module: wdt_dual_clear (top)
// Watchdog with a selectable tick source and a single or dual clear policy.
// Assumes: all inputs are synchronous to clk; src_sel and dual_mode are
// configuration values that change rarely.
module wdt_dual_clear
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       dual_mode,
    input  logic       tick_rc,
    input  logic       tick_instr,
    input  logic       tick_ext,
    input  logic       clr_single,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       timeout
);

    logic [NUM_TICK_SRC-1:0] tick_vec;
    wdt_src_e                src_e;
    logic                    tick;
    logic                    enabled;
    logic                    src_chg;
    logic                    restart;
    logic                    pend_a;
    logic                    pend_b;
    logic                    cnt_restart;
    logic [CNT_W-1:0]        count;

    // Pack the tick inputs in source-code order and type the selector.
    always_comb begin
        tick_vec    = {tick_ext, tick_instr, tick_rc};
        src_e       = wdt_src_e'(src_sel);
        cnt_restart = restart || src_chg;
    end

    wdt_tick_mux #(.NSRC(NUM_TICK_SRC)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_vec (tick_vec),
        .src_sel  (src_e),
        .tick     (tick),
        .enabled  (enabled),
        .src_chg  (src_chg)
    );

    wdt_clear_seq u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_mode  (dual_mode),
        .clr_single (clr_single),
        .clr_a      (clr_a),
        .clr_b      (clr_b),
        .flush      (src_chg),
        .restart    (restart),
        .pend_a     (pend_a),
        .pend_b     (pend_b)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enabled (enabled),
        .restart (cnt_restart),
        .count   (count),
        .timeout (timeout)
    );

endmodule

// File: rtl/wdt_dual_clear_chk.sv
// Module: wdt_dual_clear_chk
// Property checker bound to wdt_dual_clear; it observes ports and the
// signals exchanged between the submodules.
module wdt_dual_clear_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic             dual_mode,
    input logic             clr_single,
    input logic             clr_a,
    input logic             clr_b,
    input logic             src_chg,
    input logic             pend_a,
    input logic             pend_b,
    input logic [CNT_W-1:0] count,
    input logic             timeout
);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3) |=> (!timeout && count == '0));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (count == '0));

    p_single_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && clr_single) |=> (count == '0));

    p_single_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |=> (!pend_a && !pend_b));

    p_pair_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && clr_a && (pend_b || clr_b)) |=> (count == '0 && !pend_a && !pend_b));

    p_repeat_not_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && clr_a && !clr_b && !pend_b && !src_chg) |=> (pend_a && !pend_b));

    p_src_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_chg |=> (count == '0 && !pend_a && !pend_b));

endmodule

bind wdt_dual_clear wdt_dual_clear_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .dual_mode  (dual_mode),
    .clr_single (clr_single),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .src_chg    (src_chg),
    .pend_a     (pend_a),
    .pend_b     (pend_b),
    .count      (count),
    .timeout    (timeout)
);

// File: tb/wdt_dual_clear_tb.sv
`timescale 1ns/1ps
module wdt_dual_clear_tb;

    localparam int CNT_W  = 8;
    localparam int PERIOD = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       dual_mode = 1'b0;
    logic       tick_rc = 1'b0, tick_instr = 1'b0, tick_ext = 1'b0;
    logic       clr_single = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic       timeout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_dual_clear #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dual_mode(dual_mode),
        .tick_rc(tick_rc), .tick_instr(tick_instr), .tick_ext(tick_ext),
        .clr_single(clr_single), .clr_a(clr_a), .clr_b(clr_b),
        .timeout(timeout)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Reference model written from the requirements (spec of timeout).
    int   m_cnt;
    bit   m_pa, m_pb, m_to;
    logic [1:0] m_src;
    always @(posedge clk) begin
        bit chg, rs, a_now, b_now, tk;
        if (!rst_n) begin
            m_cnt = 0; m_pa = 0; m_pb = 0; m_to = 0; m_src = 2'd3;
        end else begin
            chg   = (src_sel != m_src);
            a_now = dual_mode && clr_a;
            b_now = dual_mode && clr_b;
            rs    = dual_mode ? ((a_now || m_pa) && (b_now || m_pb)) : clr_single;
            tk    = (src_sel == 2'd0 && tick_rc) || (src_sel == 2'd1 && tick_instr) ||
                    (src_sel == 2'd2 && tick_ext);
            m_to  = 0;
            if (chg || rs) m_cnt = 0;
            else if (tk) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == PERIOD) begin m_cnt = 0; m_to = 1; end
            end
            if (chg || rs || !dual_mode) begin m_pa = 0; m_pb = 0; end
            else begin
                if (a_now) m_pa = 1;
                if (b_now) m_pb = 1;
            end
            m_src = src_sel;
        end
    end

    // Compare the port against the model away from the active edge (R3).
    always @(negedge clk) begin
        if (rst_n && !done) check("R3 model", {31'd0, timeout}, {31'd0, m_to});
    end

    task automatic set_ticks(input logic [2:0] t);
        {tick_ext, tick_instr, tick_rc} = t;
    endtask

    // Apply one cycle of clear strobes; tk lets a tick collide with it.
    task automatic pulse_clr(input logic cs, input logic ca, input logic cb, input logic [2:0] tk);
        clr_single = cs; clr_a = ca; clr_b = cb; set_ticks(tk);
        @(negedge clk);
        clr_single = 0; clr_a = 0; clr_b = 0; set_ticks(3'b000);
    endtask

    task automatic set_src(input logic [1:0] s);
        src_sel = s; set_ticks(3'b000);
        @(negedge clk);
    endtask

    // Tick the chosen source every cycle, others at random; report the
    // tick number on which the timeout pulse appears (0 if none).
    task automatic count_ticks(input int sel, input int limit, output int got);
        logic [2:0] t;
        got = 0;
        for (int i = 1; i <= limit; i++) begin
            t = 3'($urandom);
            t[sel] = 1'b1;
            set_ticks(t);
            @(negedge clk);
            if (timeout) begin got = i; break; end
        end
        set_ticks(3'b000);
    endtask

    task automatic expect_period(input string rq, input int sel, input int exp);
        int got;
        count_ticks(sel, exp + 20, got);
        check(rq, got, exp);
    endtask

    task automatic advance(input string rq, input int sel, input int n);
        int got;
        count_ticks(sel, n, got);
        check(rq, got, 0);
    endtask

    initial begin
        #(20ns * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int to_seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 reset timeout", {31'd0, timeout}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: period on each source, pulse width and wrap.
        for (int s = 0; s < 3; s++) begin
            set_src(2'(s));
            expect_period("R1 period per source", s, PERIOD);
        end
        @(negedge clk);
        check("R3 pulse one cycle", {31'd0, timeout}, 32'd0);
        expect_period("R3 wrap second period", 2, PERIOD);

        // R2: off setting with every tick high.
        set_src(2'd3);
        to_seen = 0;
        set_ticks(3'b111);
        for (int i = 0; i < 3 * PERIOD; i++) begin
            @(negedge clk);
            if (timeout) to_seen++;
        end
        check("R2 off never times out", to_seen, 0);
        set_src(2'd0);
        expect_period("R2 restart after off", 0, PERIOD);

        // R4: single mode ignores A/B, honours the single strobe.
        dual_mode = 1'b0;
        advance("R4 pre", 0, 100);
        pulse_clr(1'b0, 1'b1, 1'b1, 3'b000);
        expect_period("R4 A/B ignored", 0, PERIOD - 100);
        advance("R4 pre", 0, 100);
        pulse_clr(1'b1, 1'b0, 1'b0, 3'b000);
        expect_period("R4 single restart", 0, PERIOD);

        // R9: tick in the restart cycle is not counted.
        advance("R9 pre", 0, 100);
        pulse_clr(1'b1, 1'b0, 1'b0, 3'b111);
        expect_period("R9 restart beats tick", 0, PERIOD);

        // R5: both orders and a simultaneous pair.
        dual_mode = 1'b1;
        set_src(2'd1); set_src(2'd0);
        advance("R5 pre", 0, 50);
        pulse_clr(1'b0, 1'b1, 1'b0, 3'b000);
        advance("R5 mid", 0, 50);
        pulse_clr(1'b0, 1'b0, 1'b1, 3'b000);
        expect_period("R5 A then B", 0, PERIOD);
        advance("R5 pre", 0, 50);
        pulse_clr(1'b0, 1'b0, 1'b1, 3'b000);
        advance("R5 mid", 0, 50);
        pulse_clr(1'b0, 1'b1, 1'b0, 3'b000);
        expect_period("R5 B then A", 0, PERIOD);
        advance("R5 pre", 0, 80);
        pulse_clr(1'b0, 1'b1, 1'b1, 3'b000);
        expect_period("R5 A and B together", 0, PERIOD);

        // R6: repeated A is not B; the timer expires on schedule.
        advance("R6 pre", 0, 50);
        pulse_clr(1'b0, 1'b1, 1'b0, 3'b000);
        advance("R6 mid", 0, 50);
        pulse_clr(1'b0, 1'b1, 1'b0, 3'b000);
        expect_period("R6 A twice expires", 0, PERIOD - 100);

        // R7: single strobe ignored in dual mode.
        set_src(2'd1); set_src(2'd0);
        advance("R7 pre", 0, 100);
        pulse_clr(1'b1, 1'b0, 1'b0, 3'b000);
        expect_period("R7 single ignored", 0, PERIOD - 100);

        // R8: source change restarts and drops a pending A.
        set_src(2'd1); set_src(2'd0);
        advance("R8 pre", 0, 60);
        pulse_clr(1'b0, 1'b1, 1'b0, 3'b000);
        set_src(2'd1);
        advance("R8 mid", 1, 50);
        pulse_clr(1'b0, 1'b0, 1'b1, 3'b000);
        expect_period("R8 flush on source change", 1, PERIOD - 50);

        // Constrained random run compared against the model (R3, R5, R8).
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 499) == 0) src_sel = 2'($urandom);
            if ($urandom_range(0, 999) == 0) dual_mode = ~dual_mode;
            set_ticks(3'($urandom));
            clr_single = ($urandom_range(0, 299) == 0);
            clr_a      = ($urandom_range(0, 199) == 0);
            clr_b      = ($urandom_range(0, 199) == 0);
            @(negedge clk);
        end
        clr_single = 0; clr_a = 0; clr_b = 0; set_ticks(3'b000);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule